// File: doc/BRIEF.md
# Parallel Printer Port Host Register File

This block is the register set a host processor sees for a PC-style parallel printer port. A small synchronous bus with a 2-bit offset, write and read strobes, and 8-bit data paths reaches three byte registers: a data latch that drives the printer data lines, a status view of the printer's handshake and fault inputs, and a control register whose lowest bit drives the active-low strobe line.

The status view has one stored bit, a sticky timeout flag. A small state machine sets it when, in the enhanced (EPP) mode, a cycle has waited on the peripheral for longer than a 10 µs budget, counted in system clocks. The host clears the flag by writing a one to its bit. All other status bits show the pins as they are, and one of them is inverted. Read data is registered. A status read samples the pins on the first edge of the read and keeps that byte for as long as the read strobe stays high.

Two state machines carry the timing. The timeout machine has the states TMO_IDLE, TMO_COUNT, TMO_FIRE and TMO_HOLD. It moves TMO_IDLE→TMO_COUNT when a wait begins in EPP mode. It moves TMO_COUNT→TMO_IDLE if the wait ends early, and TMO_COUNT→TMO_FIRE when the budget is used up. From TMO_FIRE it moves to TMO_HOLD while the wait lasts and to TMO_IDLE otherwise, and it moves TMO_HOLD→TMO_IDLE when the wait ends. The read machine has the states RD_IDLE and RD_BUSY. It moves RD_IDLE→RD_BUSY on the first edge with the read strobe high and RD_BUSY→RD_IDLE when the strobe drops.

Top module: `pport_regfile`

## Requirements
- R1: After reset, pd_out is 0x00, strobe_n_out is 1, pd_oe is 1, the control register reads 0x00 and the timeout flag is 0.
- R2: A write at offset 0 loads the data latch, and pd_out shows that byte unchanged from the next cycle. pd_oe is 1 exactly when control bit 5 is 0.
- R3: A read at offset 0 returns pd_in when epp_mode is 0 and is refreshed on every cycle of the read. When epp_mode is 1 it returns the data latch.
- R4: bus_rdata is updated on the clock edge at which bus_rd is sampled high. A read at offset 1 takes the status byte on its first edge and keeps it while bus_rd stays high at offset 1.
- R5: Status encoding: bit 7 is the inverse of busy_in, bit 6 is ack_n_in, bit 5 is paper_out_in, bit 4 is sel_in, bit 3 is err_n_in, and bits 2 and 1 read 0.
- R6: Status bit 0 shows the timeout flag when epp_mode is 1 and reads 0 when epp_mode is 0. The flag itself is kept in either mode.
- R7: With epp_mode at 1, the flag is set one cycle after epp_wait has been sampled high on TMO_CYCLES consecutive edges. That is 500 cycles for the default 50 MHz clock and 10 µs budget. A shorter wait, or any wait with epp_mode at 0, leaves the flag at 0.
- R8: A write at offset 1 with bit 0 set clears the flag in one cycle. A write with bit 0 clear has no effect. The other written status bits are ignored.
- R9: If the timeout fires in the same cycle as a clearing write, the flag ends up set.
- R10: Control bits 5..0 are stored and read back, bits 7 and 6 read 0, and strobe_n_out is the inverse of control bit 0.
- R11: A read at offset 3 returns 0x00. A write at offset 3 changes no register or output.
- R12: One uninterrupted wait raises the timeout at most once, as a single-cycle pulse. After a clear during the same wait, the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_rd | input | 1 | Read strobe, held high for the length of a read |
| bus_rdata | output | 8 | Registered read data |
| pd_out | output | 8 | Value driven onto the printer data lines |
| pd_oe | output | 1 | Output enable for the printer data lines |
| pd_in | input | 8 | Level sensed on the printer data lines |
| err_n_in | input | 1 | Printer fault, active low |
| sel_in | input | 1 | Printer on-line |
| paper_out_in | input | 1 | Paper exhausted |
| ack_n_in | input | 1 | Character acknowledge, active low |
| busy_in | input | 1 | Printer busy |
| strobe_n_out | output | 1 | Data strobe to printer, active low |
| epp_mode | input | 1 | 1 selects enhanced mode, 0 standard mode |
| epp_wait | input | 1 | High while an enhanced-mode cycle waits on the peripheral |

## Verification
The bench probes the edges of the timeout window. A wait one cycle short of the budget must not set the flag, and a wait of exactly the budget must set it. A counter that is off by one fails one of these two cases. A clearing write is placed in the very cycle the timeout fires: a design that lets the clear win would read 0 there. A clear is also issued in the middle of a long wait, where a design that re-arms the counter would set the flag again. Pins change during a held status read, where a design that samples status live would return the new byte. The bench also checks that the data port returns the pins in standard mode but the latch in enhanced mode, and that status bit 0 is hidden in standard mode.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 2;
    localparam int CTRL_W = 6;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 2'd0,
        OFS_STAT = 2'd1,
        OFS_CTRL = 2'd2,
        OFS_RSVD = 2'd3
    } ofs_e;

    typedef enum logic [1:0] {
        TMO_IDLE,
        TMO_COUNT,
        TMO_FIRE,
        TMO_HOLD
    } tmo_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_BUSY
    } rd_state_e;

endpackage

// File: rtl/pport_decode.sv
module pport_decode
    import pport_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             wr,
    input  logic             wbit0,
    output logic             we_data,
    output logic             we_ctrl,
    output logic             tmo_clr
);

    always_comb begin
        we_data = 1'b0;
        we_ctrl = 1'b0;
        tmo_clr = 1'b0;
        if (wr) begin
            unique case (ofs_e'(addr))
                OFS_DATA: we_data = 1'b1;
                OFS_STAT: tmo_clr = wbit0;
                OFS_CTRL: we_ctrl = 1'b1;
                OFS_RSVD: ;
            endcase
        end
    end

endmodule

// File: rtl/pport_tmo_fsm.sv
module pport_tmo_fsm
    import pport_pkg::*;
#(
    parameter int TMO_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic epp_mode,
    input  logic epp_wait,
    output logic tmo_pulse
);

    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

    tmo_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic waiting;

    assign waiting = epp_mode & epp_wait;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TMO_COUNT) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= CW'(1);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMO_IDLE:  if (waiting) state_d = TMO_COUNT;
            TMO_COUNT: begin
                if (!waiting)           state_d = TMO_IDLE;
                else if (cnt_q == LAST) state_d = TMO_FIRE;
            end
            TMO_FIRE:  state_d = waiting ? TMO_HOLD : TMO_IDLE;
            TMO_HOLD:  if (!waiting) state_d = TMO_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TMO_FIRE: tmo_pulse = 1'b1;
            TMO_IDLE, TMO_COUNT, TMO_HOLD: tmo_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/pport_rd_fsm.sv
module pport_rd_fsm
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [OFS_W-1:0]  addr,
    input  logic [BYTE_W-1:0] live,
    output logic [BYTE_W-1:0] rdata
);

    rd_state_e state_q, state_d;
    logic [BYTE_W-1:0] rdata_q;
    logic capture;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd)  state_d = RD_BUSY;
            RD_BUSY: if (!rd) state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: capture = rd;
            RD_BUSY: capture = rd && (ofs_e'(addr) != OFS_STAT);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (capture) rdata_q <= live;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pport_regfile.sv
module pport_regfile
    import pport_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int TMO_US = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           bus_addr,
    input  logic [7:0]           bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [7:0]           bus_rdata,
    output logic [7:0]           pd_out,
    output logic                 pd_oe,
    input  logic [7:0]           pd_in,
    input  logic                 err_n_in,
    input  logic                 sel_in,
    input  logic                 paper_out_in,
    input  logic                 ack_n_in,
    input  logic                 busy_in,
    output logic                 strobe_n_out,
    input  logic                 epp_mode,
    input  logic                 epp_wait
);

    localparam int TMO_CYCLES = (CLK_HZ / 1_000_000) * TMO_US;

    logic we_data, we_ctrl, tmo_clr, tmo_pulse;
    logic [BYTE_W-1:0] data_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              tmo_flag;
    logic [BYTE_W-1:0] status_live, live;

    pport_decode i_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wbit0   (bus_wdata[0]),
        .we_data (we_data),
        .we_ctrl (we_ctrl),
        .tmo_clr (tmo_clr)
    );

    pport_tmo_fsm #(.TMO_CYCLES(TMO_CYCLES)) i_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .epp_mode  (epp_mode),
        .epp_wait  (epp_wait),
        .tmo_pulse (tmo_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            ctrl_q   <= '0;
            tmo_flag <= 1'b0;
        end else begin
            if (we_data) data_q <= bus_wdata;
            if (we_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (tmo_pulse)    tmo_flag <= 1'b1;
            else if (tmo_clr) tmo_flag <= 1'b0;
        end
    end

    assign status_live = {~busy_in, ack_n_in, paper_out_in, sel_in, err_n_in,
                          2'b00, tmo_flag & epp_mode};

    always_comb begin
        unique case (ofs_e'(bus_addr))
            OFS_DATA: live = epp_mode ? data_q : pd_in;
            OFS_STAT: live = status_live;
            OFS_CTRL: live = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_RSVD: live = '0;
        endcase
    end

    pport_rd_fsm i_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .live  (live),
        .rdata (bus_rdata)
    );

    assign pd_out       = data_q;
    assign pd_oe        = ~ctrl_q[5];
    assign strobe_n_out = ~ctrl_q[0];

endmodule

// File: rtl/pport_regfile_chk.sv
module pport_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic [7:0] pd_out,
    input logic       strobe_n_out,
    input logic       tmo_pulse,
    input logic       tmo_flag
);

    p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> pd_out == $past(bus_wdata));

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> strobe_n_out == ~$past(bus_wdata[0]));

    p_ctrl_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2) |=> bus_rdata[7:6] == 2'b00);

    p_stat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1 && $past(bus_rd) && $past(bus_addr) == 2'd1)
        |=> $stable(bus_rdata));

    p_stat_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1 && !$past(bus_rd)) |=> bus_rdata[2:1] == 2'b00);

    p_rsvd_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3 && !$past(bus_rd)) |=> bus_rdata == 8'h00);

    p_rsvd_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(pd_out) && $stable(strobe_n_out)));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> tmo_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[0] && !tmo_pulse) |=> !tmo_flag);

    p_w0_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !bus_wdata[0] && tmo_flag) |=> tmo_flag);

    p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> !tmo_pulse);

endmodule

bind pport_regfile pport_regfile_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .pd_out       (pd_out),
    .strobe_n_out (strobe_n_out),
    .tmo_pulse    (tmo_pulse),
    .tmo_flag     (tmo_flag)
);

// File: tb/test_pport_regfile.sv
module test_pport_regfile;

    localparam int L = 500;   // 10 us at 50 MHz

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata, pd_out;
    logic pd_oe, strobe_n_out;
    logic [7:0] pd_in = '0;
    logic err_n_in = 1'b1, sel_in = 1'b0, paper_out_in = 1'b0;
    logic ack_n_in = 1'b1, busy_in = 1'b0;
    logic epp_mode = 1'b0, epp_wait = 1'b0;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    pport_regfile i_pport_regfile (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .err_n_in(err_n_in), .sel_in(sel_in), .paper_out_in(paper_out_in),
        .ack_n_in(ack_n_in), .busy_in(busy_in), .strobe_n_out(strobe_n_out),
        .epp_mode(epp_mode), .epp_wait(epp_wait)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_exp(input logic flag_vis);
        return {~busy_in, ack_n_in, paper_out_in, sel_in, err_n_in, 2'b00, flag_vis};
    endfunction

    // monitor: one expected item per edge with bus_rd high
    initial begin
        forever begin
            logic rd_s;
            @(posedge clk);
            rd_s = bus_rd;
            #5;
            if (rd_s) begin
                if (exp_q.size() == 0) check("monitor queue empty", bus_rdata, 8'hxx);
                else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic push(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd1(input logic [1:0] a, input logic [7:0] e, input string t);
        bus_addr = a; bus_rd = 1'b1; push(e, t);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pd_out", pd_out, 8'h00);
        check("R1 strobe_n", {7'd0, strobe_n_out}, 8'h01);
        check("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
        rd1(2'd2, 8'h00, "R1 ctrl read");
        epp_mode = 1'b1;
        rd1(2'd1, stat_exp(1'b0), "R1 flag clear");
        epp_mode = 1'b0;

        // R2 data latch
        wr(2'd0, 8'hA5); check("R2 pd_out A5", pd_out, 8'hA5);
        wr(2'd0, 8'h3C); check("R2 pd_out 3C", pd_out, 8'h3C);

        // R3 data read: pins in SPP, refreshed each cycle; latch in EPP
        pd_in = 8'h5A;
        rd1(2'd0, 8'h5A, "R3 spp pins");
        bus_addr = 2'd0; bus_rd = 1'b1; push(8'h66, "R3 spp cycle1"); pd_in = 8'h66;
        @(negedge clk); pd_in = 8'h81; push(8'h81, "R3 spp cycle2");
        @(negedge clk); bus_rd = 1'b0; @(negedge clk);
        epp_mode = 1'b1;
        rd1(2'd0, 8'h3C, "R3 epp latch");
        epp_mode = 1'b0;

        // R5 status encoding under several pin patterns
        busy_in = 1'b1; ack_n_in = 1'b0; paper_out_in = 1'b1; sel_in = 1'b0; err_n_in = 1'b1;
        rd1(2'd1, 8'b0010_1000, "R5 pattern A");
        busy_in = 1'b0; ack_n_in = 1'b1; paper_out_in = 1'b0; sel_in = 1'b1; err_n_in = 1'b0;
        rd1(2'd1, 8'b1101_0000, "R5 pattern B");
        busy_in = 1'b1; ack_n_in = 1'b1; paper_out_in = 1'b1; sel_in = 1'b1; err_n_in = 1'b1;
        rd1(2'd1, 8'b0111_1000, "R5 pattern C");

        // R4 held status read while pins change
        held = stat_exp(1'b0);
        bus_addr = 2'd1; bus_rd = 1'b1; push(held, "R4 hold c1");
        @(negedge clk);
        busy_in = 1'b0; ack_n_in = 1'b0; sel_in = 1'b0; push(held, "R4 hold c2");
        @(negedge clk); push(held, "R4 hold c3");
        @(negedge clk); bus_rd = 1'b0; @(negedge clk);
        rd1(2'd1, stat_exp(1'b0), "R4 new read sees new pins");

        // R10 control register
        wr(2'd2, 8'hFF);
        check("R10 strobe low", {7'd0, strobe_n_out}, 8'h00);
        check("R2 pd_oe off by ctrl bit5", {7'd0, pd_oe}, 8'h00);
        rd1(2'd2, 8'h3F, "R10 ctrl read bits76 zero");
        wr(2'd2, 8'h00);
        check("R10 strobe high", {7'd0, strobe_n_out}, 8'h01);
        wr(2'd2, 8'h01);
        check("R10 strobe low again", {7'd0, strobe_n_out}, 8'h00);

        // R11 reserved offset
        wr(2'd3, 8'hFE);
        check("R11 pd_out kept", pd_out, 8'h3C);
        check("R11 strobe kept", {7'd0, strobe_n_out}, 8'h00);
        rd1(2'd3, 8'h00, "R11 read zero");
        rd1(2'd2, 8'h01, "R11 ctrl kept");

        // R7 long wait in SPP mode sets nothing
        epp_wait = 1'b1; repeat (L + 20) @(negedge clk); epp_wait = 1'b0;
        @(negedge clk); epp_mode = 1'b1;
        rd1(2'd1, stat_exp(1'b0), "R7 spp wait no flag");

        // R7 one short of budget
        epp_wait = 1'b1; repeat (L - 1) @(negedge clk); epp_wait = 1'b0;
        @(negedge clk);
        rd1(2'd1, stat_exp(1'b0), "R7 short wait");

        // R7 exactly the budget
        epp_wait = 1'b1; repeat (L) @(negedge clk); epp_wait = 1'b0;
        @(negedge clk);
        rd1(2'd1, stat_exp(1'b1), "R7 exact wait sets flag");

        // R6 flag hidden in SPP
        epp_mode = 1'b0;
        rd1(2'd1, stat_exp(1'b0), "R6 flag hidden spp");
        epp_mode = 1'b1;
        rd1(2'd1, stat_exp(1'b1), "R6 flag shown epp");

        // R8 write 0 keeps, write 1 clears
        wr(2'd1, 8'hFE);
        rd1(2'd1, stat_exp(1'b1), "R8 write0 no effect");
        wr(2'd1, 8'h01);
        rd1(2'd1, stat_exp(1'b0), "R8 write1 clears");

        // R12 clear mid-wait does not re-arm
        epp_wait = 1'b1; repeat (L + 3) @(negedge clk);
        wr(2'd1, 8'h01);
        repeat (L + 5) @(negedge clk);
        rd1(2'd1, stat_exp(1'b0), "R12 no second timeout");
        epp_wait = 1'b0; @(negedge clk);

        // R9 clear in the firing cycle
        epp_wait = 1'b1; repeat (L) @(negedge clk);
        wr(2'd1, 8'h01);
        epp_wait = 1'b0; @(negedge clk);
        rd1(2'd1, stat_exp(1'b1), "R9 set wins");
        wr(2'd1, 8'h01);
        rd1(2'd1, stat_exp(1'b0), "R8 clear after set wins");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule